// File: doc/BRIEF.md
# Three-Operand Integer Execute Slice

This block decodes and executes one 32-bit integer instruction per clock. Each word is either a register-format operation (two register sources, one register destination, operation picked by a function code) or an immediate-format operation (one register source, a 16-bit constant, and a destination taken from the second register field). Two operands come from a 32 x 32-bit register file. A small ALU computes the result, which is written back at the next rising clock edge.

The write-back index, value and enable appear on the ports in the same cycle as the instruction, so a test harness can see every retirement. An instruction the slice does not recognise writes nothing and raises a flag. Register 0 is hardwired to zero. A full 32-bit constant is built by a load-upper-immediate followed by an or-immediate.

Top module: `int_exec_slice`

## Requirements
- R1: An active-low reset clears every register to zero. While reset is held, or while `instr_valid_i` is low, no write-back is reported.
- R2: Register format is opcode[31:26]=000000, rs[25:21], rt[20:16], rd[15:11], shamt[10:6], funct[5:0]. Funct 100000 writes rs+rt (modulo 2^32) into rd.
- R3: Funct 100010 writes rs-rt (modulo 2^32) into rd.
- R4: Funct 101010 writes 1 into rd when rs < rt as signed two's-complement values, and 0 otherwise.
- R5: Immediate format is opcode[31:26], rs[25:21], rt[20:16], imm[15:0], with rt as the destination. Opcode 001000 writes rs + sign-extended imm into rt.
- R6: Opcode 001010 writes 1 into rt when rs < sign-extended imm (signed), and 0 otherwise.
- R7: Opcode 001100 writes rs AND zero-extended imm into rt. Opcode 001101 writes rs OR zero-extended imm into rt.
- R8: Opcode 001111 writes {imm, 16'h0000} into rt. Following it with opcode 001101 on the same register leaves the full 32-bit constant there.
- R9: Register 0 always reads as zero. An instruction that names it as destination still reports its write-back on the ports, but the register file keeps the value zero.
- R10: An unknown opcode, an unknown funct, or a register-format word with non-zero shamt raises `illegal_o`, reports no write-back and leaves every register unchanged.
- R11: A result written at a rising edge is read by the very next instruction, with no delay slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; write-back takes effect on the rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| instr_valid_i | input | 1 | Marks `instr_i` as an instruction to execute this cycle |
| instr_i | input | 32 | Instruction word |
| wb_en_o | output | 1 | A register write-back happens at the coming edge |
| wb_idx_o | output | 5 | Destination register index |
| wb_data_o | output | 32 | Value being written back |
| illegal_o | output | 1 | The valid instruction this cycle is not recognised |

## Verification
The bench goes after the sign handling of immediates. If addi zero-extended a negative constant, or andi sign-extended 0xF0F0, the result would carry wrong upper bits. A signed comparison done unsigned would report -3 as larger than 100. It checks that lui clears the low half, since a design that kept old low bits would break the lui/ori constant build. It writes to register 0 and reads it back to catch a register file that stores there. It sends illegal words and reads the named destination afterwards, to catch a write that leaks through. Back-to-back dependent instructions and a long stream of generated instructions, checked against a behavioural model, expose a wrong destination field or a stale read.

// File: rtl/iex_pkg.sv
package iex_pkg;

    localparam int XLEN = 32;

    localparam logic [5:0] OPC_RTYPE = 6'b000000;
    localparam logic [5:0] OPC_ADDI  = 6'b001000;
    localparam logic [5:0] OPC_SLTI  = 6'b001010;
    localparam logic [5:0] OPC_ANDI  = 6'b001100;
    localparam logic [5:0] OPC_ORI   = 6'b001101;
    localparam logic [5:0] OPC_LUI   = 6'b001111;

    localparam logic [5:0] FN_ADD = 6'b100000;
    localparam logic [5:0] FN_SUB = 6'b100010;
    localparam logic [5:0] FN_SLT = 6'b101010;

    typedef enum logic [2:0] {
        ALU_ADD,
        ALU_SUB,
        ALU_SLT,
        ALU_AND,
        ALU_OR,
        ALU_LUI
    } alu_op_e;

endpackage

// File: rtl/iex_decode.sv
module iex_decode
    import iex_pkg::*;
#(
    parameter int REG_AW = 5
) (
    input  logic              valid_i,
    input  logic [XLEN-1:0]   instr_i,
    output alu_op_e           alu_op_o,
    output logic              use_imm_o,
    output logic [XLEN-1:0]   imm_ext_o,
    output logic [REG_AW-1:0] rs_o,
    output logic [REG_AW-1:0] rt_o,
    output logic [REG_AW-1:0] dst_o,
    output logic              wr_en_o,
    output logic              illegal_o
);

    logic [5:0]  opc;
    logic [5:0]  fn;
    logic [4:0]  sh;
    logic [15:0] imm;
    logic        legal;

    assign opc  = instr_i[31:26];
    assign fn   = instr_i[5:0];
    assign sh   = instr_i[10:6];
    assign imm  = instr_i[15:0];
    assign rs_o = instr_i[25:21];
    assign rt_o = instr_i[20:16];

    always_comb begin
        alu_op_o  = ALU_ADD;
        use_imm_o = 1'b0;
        imm_ext_o = {{(XLEN-16){imm[15]}}, imm};
        dst_o     = instr_i[15:11];
        legal     = 1'b0;
        unique case (opc)
            OPC_RTYPE: begin
                if (sh == 5'd0) begin
                    unique case (fn)
                        FN_ADD:  begin alu_op_o = ALU_ADD; legal = 1'b1; end
                        FN_SUB:  begin alu_op_o = ALU_SUB; legal = 1'b1; end
                        FN_SLT:  begin alu_op_o = ALU_SLT; legal = 1'b1; end
                        default: legal = 1'b0;
                    endcase
                end
            end
            OPC_ADDI: begin
                alu_op_o = ALU_ADD; use_imm_o = 1'b1; dst_o = rt_o; legal = 1'b1;
            end
            OPC_SLTI: begin
                alu_op_o = ALU_SLT; use_imm_o = 1'b1; dst_o = rt_o; legal = 1'b1;
            end
            OPC_ANDI: begin
                alu_op_o = ALU_AND; use_imm_o = 1'b1; dst_o = rt_o; legal = 1'b1;
                imm_ext_o = {{(XLEN-16){1'b0}}, imm};
            end
            OPC_ORI: begin
                alu_op_o = ALU_OR; use_imm_o = 1'b1; dst_o = rt_o; legal = 1'b1;
                imm_ext_o = {{(XLEN-16){1'b0}}, imm};
            end
            OPC_LUI: begin
                alu_op_o = ALU_LUI; use_imm_o = 1'b1; dst_o = rt_o; legal = 1'b1;
                imm_ext_o = {{(XLEN-16){1'b0}}, imm};
            end
            default: legal = 1'b0;
        endcase
    end

    assign wr_en_o   = valid_i & legal;
    assign illegal_o = valid_i & ~legal;

endmodule

// File: rtl/iex_alu.sv
module iex_alu
    import iex_pkg::*;
(
    input  alu_op_e         op_i,
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    output logic [XLEN-1:0] y_o
);

    logic lt;
    assign lt = $signed(a_i) < $signed(b_i);

    always_comb begin
        unique case (op_i)
            ALU_ADD: y_o = a_i + b_i;
            ALU_SUB: y_o = a_i - b_i;
            ALU_SLT: y_o = {{(XLEN-1){1'b0}}, lt};
            ALU_AND: y_o = a_i & b_i;
            ALU_OR:  y_o = a_i | b_i;
            ALU_LUI: y_o = {b_i[15:0], {(XLEN-16){1'b0}}};
            default: y_o = '0;
        endcase
    end

endmodule

// File: rtl/iex_regfile.sv
module iex_regfile #(
    parameter int WIDTH    = 32,
    parameter int DEPTH    = 32,
    parameter int RD_PORTS = 2,
    localparam int AW      = $clog2(DEPTH)
) (
    input  logic                             clk_i,
    input  logic                             rst_ni,
    input  logic [RD_PORTS-1:0][AW-1:0]      rd_idx_i,
    output logic [RD_PORTS-1:0][WIDTH-1:0]   rd_data_o,
    input  logic                             wr_en_i,
    input  logic [AW-1:0]                    wr_idx_i,
    input  logic [WIDTH-1:0]                 wr_data_i
);

    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wr_en_i && (wr_idx_i != '0)) begin
            mem[wr_idx_i] <= wr_data_i;
        end
    end

    for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
        assign rd_data_o[p] = (rd_idx_i[p] == '0) ? '0 : mem[rd_idx_i[p]];
    end

endmodule

// File: rtl/int_exec_slice.sv
module int_exec_slice
    import iex_pkg::*;
#(
    parameter int NUM_REGS = 32,
    localparam int REG_AW  = $clog2(NUM_REGS)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              instr_valid_i,
    input  logic [XLEN-1:0]   instr_i,
    output logic              wb_en_o,
    output logic [REG_AW-1:0] wb_idx_o,
    output logic [XLEN-1:0]   wb_data_o,
    output logic              illegal_o
);

    alu_op_e                       alu_op;
    logic                          use_imm;
    logic [XLEN-1:0]               imm_ext;
    logic [REG_AW-1:0]             rs, rt, dst;
    logic                          wr_en;
    logic [1:0][REG_AW-1:0]        rd_idx;
    logic [1:0][XLEN-1:0]          rd_data;
    logic [XLEN-1:0]               op_b;
    logic [XLEN-1:0]               result;

    iex_decode #(.REG_AW(REG_AW)) u_dec (
        .valid_i   (instr_valid_i),
        .instr_i   (instr_i),
        .alu_op_o  (alu_op),
        .use_imm_o (use_imm),
        .imm_ext_o (imm_ext),
        .rs_o      (rs),
        .rt_o      (rt),
        .dst_o     (dst),
        .wr_en_o   (wr_en),
        .illegal_o (illegal_o)
    );

    assign rd_idx[0] = rs;
    assign rd_idx[1] = rt;

    iex_regfile #(.WIDTH(XLEN), .DEPTH(NUM_REGS), .RD_PORTS(2)) u_rf (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .rd_idx_i  (rd_idx),
        .rd_data_o (rd_data),
        .wr_en_i   (wr_en),
        .wr_idx_i  (dst),
        .wr_data_i (result)
    );

    assign op_b = use_imm ? imm_ext : rd_data[1];

    iex_alu u_alu (
        .op_i (alu_op),
        .a_i  (rd_data[0]),
        .b_i  (op_b),
        .y_o  (result)
    );

    assign wb_en_o   = wr_en & rst_ni;
    assign wb_idx_o  = dst;
    assign wb_data_o = result;

endmodule

// File: rtl/int_exec_slice_chk.sv
module int_exec_slice_chk (
    input logic        clk_i,
    input logic        rst_ni,
    input logic        instr_valid_i,
    input logic [31:0] instr_i,
    input logic        wb_en_o,
    input logic [4:0]  wb_idx_o,
    input logic [31:0] wb_data_o,
    input logic        illegal_o
);

    logic is_r;
    assign is_r = instr_i[31:26] == 6'b000000;

    a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !instr_valid_i |-> (!wb_en_o && !illegal_o));

    a_r10_illegal_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
        illegal_o |-> !wb_en_o);

    a_r10_shamt_illegal: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (instr_valid_i && is_r && instr_i[10:6] != 5'd0) |-> illegal_o);

    a_r2_rd_dest: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (instr_valid_i && is_r && instr_i[10:6] == 5'd0 && instr_i[5:0] == 6'b100000)
        |-> (wb_en_o && wb_idx_o == instr_i[15:11]));

    a_r4_slt_boolean: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wb_en_o && is_r && instr_i[5:0] == 6'b101010) |-> (wb_data_o[31:1] == 31'd0));

    a_r5_rt_dest: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (instr_valid_i && instr_i[31:26] == 6'b001000) |-> (wb_en_o && wb_idx_o == instr_i[20:16]));

    a_r8_lui_low_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (instr_valid_i && instr_i[31:26] == 6'b001111)
        |-> (wb_en_o && wb_data_o == {instr_i[15:0], 16'h0000}));

endmodule

bind int_exec_slice int_exec_slice_chk chk_i (.*);

// File: tb/int_exec_slice_tb_top.sv
module int_exec_slice_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        instr_valid_i = 1'b0;
    logic [31:0] instr_i = '0;
    logic        wb_en_o;
    logic [4:0]  wb_idx_o;
    logic [31:0] wb_data_o;
    logic        illegal_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    logic [31:0] model [32];
    logic [31:0] lfsr = 32'hACE1_2024;

    always #(CLK_PERIOD/2) clk_i = ~clk_i;

    int_exec_slice dut_i (
        .clk_i, .rst_ni, .instr_valid_i, .instr_i,
        .wb_en_o, .wb_idx_o, .wb_data_o, .illegal_o
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] rfmt(input logic [5:0] fn, input int rs, input int rt, input int rd);
        return {6'b000000, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn};
    endfunction

    function automatic logic [31:0] ifmt(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
        return {op, rs[4:0], rt[4:0], imm};
    endfunction

    // Behavioural reference: what the requirements say one instruction does.
    task automatic predict(input logic [31:0] ins, input bit vld, output bit en, output bit ill,
                           output int dst, output logic [31:0] val);
        logic [31:0] a, b, sx, zx;
        int op, fn;
        op = int'(ins[31:26]); fn = int'(ins[5:0]);
        a  = (ins[25:21] == 0) ? 32'd0 : model[ins[25:21]];
        b  = (ins[20:16] == 0) ? 32'd0 : model[ins[20:16]];
        sx = 32'($signed(ins[15:0]));
        zx = {16'd0, ins[15:0]};
        en = 1; ill = 0; dst = int'(ins[20:16]); val = 0;
        case (op)
            0: begin
                dst = int'(ins[15:11]);
                if (ins[10:6] != 0) begin en = 0; ill = 1; end
                else if (fn == 32) val = a + b;
                else if (fn == 34) val = a - b;
                else if (fn == 42) val = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
                else begin en = 0; ill = 1; end
            end
            8:  val = a + sx;
            10: val = ($signed(a) < $signed(sx)) ? 32'd1 : 32'd0;
            12: val = a & zx;
            13: val = a | zx;
            15: val = {ins[15:0], 16'd0};
            default: begin en = 0; ill = 1; end
        endcase
        if (!vld) begin en = 0; ill = 0; end
    endtask

    task automatic exec(input logic [31:0] ins, input bit vld, input string req);
        bit en, ill; int dst; logic [31:0] val;
        @(negedge clk_i);
        instr_i = ins; instr_valid_i = vld;
        predict(ins, vld, en, ill, dst, val);
        #(CLK_PERIOD/4);
        chk(wb_en_o == en, req, "wb_en", 32'(wb_en_o), 32'(en));
        chk(illegal_o == ill, req, "illegal", 32'(illegal_o), 32'(ill));
        if (en) begin
            chk(wb_idx_o == dst[4:0], req, "wb_idx", 32'(wb_idx_o), 32'(dst));
            chk(wb_data_o == val, req, "wb_data", wb_data_o, val);
            if (dst != 0) model[dst] = val;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 32; i++) model[i] = '0;
        // R1: outputs quiet in reset even with a valid instruction offered
        instr_valid_i = 1'b1; instr_i = ifmt(6'b001000, 0, 1, 16'd5);
        #(CLK_PERIOD*2 + CLK_PERIOD/4);
        chk(wb_en_o == 1'b0, "R1", "wb_en in reset", 32'(wb_en_o), 0);
        @(negedge clk_i); rst_ni = 1'b1; instr_valid_i = 1'b0;

        exec(rfmt(6'b100000, 5, 7, 1), 1, "R1");            // registers read zero after reset
        exec(ifmt(6'b001000, 0, 1, 16'd100), 1, "R5");
        exec(ifmt(6'b001000, 0, 2, 16'hFFFD), 1, "R5");      // -3, sign-extended
        exec(rfmt(6'b100000, 1, 2, 3), 1, "R11");           // back-to-back use: 97
        exec(rfmt(6'b100010, 2, 1, 4), 1, "R3");            // -103
        exec(rfmt(6'b101010, 2, 1, 5), 1, "R4");            // -3 < 100 signed -> 1
        exec(rfmt(6'b101010, 1, 2, 6), 1, "R4");            // 0
        exec(ifmt(6'b001010, 2, 7, 16'hFFFF), 1, "R6");     // -3 < -1 -> 1
        exec(ifmt(6'b001010, 1, 8, 16'd5), 1, "R6");        // 100 < 5 -> 0
        exec(ifmt(6'b001100, 2, 9, 16'hF0F0), 1, "R7");     // zero-extended and
        exec(ifmt(6'b001101, 0, 10, 16'h8001), 1, "R7");    // zero-extended or
        exec(ifmt(6'b001111, 0, 11, 16'hABCD), 1, "R8");
        exec(ifmt(6'b001101, 11, 11, 16'h1234), 1, "R8");
        exec(rfmt(6'b100000, 11, 0, 12), 1, "R8");          // 0xABCD1234 read back
        exec(ifmt(6'b001000, 0, 0, 16'd55), 1, "R9");       // write to r0 reported
        exec(rfmt(6'b100000, 0, 0, 13), 1, "R9");           // r0 still zero
        exec(ifmt(6'b000100, 0, 1, 16'd7), 1, "R10");       // unknown opcode, rt=1
        exec(rfmt(6'b000000, 1, 1, 1), 1, "R10");           // unknown funct
        exec({6'b000000, 5'd1, 5'd1, 5'd1, 5'd3, 6'b100000}, 1, "R10"); // shamt set
        exec(rfmt(6'b100000, 1, 0, 14), 1, "R10");          // r1 still 100
        exec(ifmt(6'b001000, 0, 1, 16'd9), 0, "R1");        // not valid: no write
        exec(rfmt(6'b100000, 1, 0, 15), 1, "R1");           // r1 still 100

        for (int n = 0; n < 300; n++) begin
            logic [5:0] ops [6];
            logic [31:0] ins;
            ops = '{6'b000000, 6'b001000, 6'b001010, 6'b001100, 6'b001101, 6'b001111};
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            ins = ifmt(ops[lfsr[2:0] % 6], int'(lfsr[10:8]), int'(lfsr[13:11]), lfsr[31:16]);
            if (ins[31:26] == 6'b000000) begin
                ins[10:6] = 5'd0;
                ins[5:0]  = (lfsr[4:3] == 2'd0) ? 6'b100010 :
                            (lfsr[4:3] == 2'd1) ? 6'b101010 : 6'b100000;
            end
            exec(ins, 1, "R11");
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule